// File: doc/BRIEF.md
# Interrupt Destination Router

The block takes one inter-processor interrupt command per strobe and decides which of `N_AGENTS` agents should receive it. Each agent presents its 8-bit physical ID, its 8-bit logical ID, a 4-bit addressing-model code and an enable flag. The command carries a source agent index, an 8-bit destination, a physical/logical select, a 2-bit shorthand and a 3-bit delivery type.

For ordinary delivery types, every agent that matches the destination is flagged. For lowest-priority delivery, the matched agents form a candidate set. Exactly one of them is chosen by a rotating search that favours enabled agents. A fixed fallback applies when none of the candidates is enabled. The result is a target mask with a one-cycle valid pulse, which the delivery logic downstream consumes.

Top module: `ipi_route`

## Requirements
- R1: `tgt_valid_o` is high for exactly the cycle after a cycle with `cmd_valid_i` high, and `tgt_mask_o` carries that command's result in the same cycle. In any cycle where `tgt_valid_o` is low, `tgt_mask_o` is zero.
- R2: The shorthand field is decoded as follows, and values 1 to 3 ignore the destination and the physical/logical select:
  - 0: address by the destination field.
  - 1: only the source agent.
  - 2: every agent.
  - 3: every agent except the source.
- R3: With shorthand 0 and `cmd_logical_i` low, an agent matches when the destination equals its physical ID, or when the destination is 8'hFF.
- R4: With shorthand 0 and `cmd_logical_i` high, an agent whose model code is 4'hF (flat) matches when the bitwise AND of its logical ID and the destination is nonzero.
- R5: With shorthand 0 and `cmd_logical_i` high, an agent whose model code is 4'h0 (cluster) matches when two conditions hold:
  - The upper nibbles of its logical ID and the destination are equal.
  - The AND of the two lower nibbles is nonzero.
- R6: With shorthand 0 and `cmd_logical_i` high, an agent whose model code is any value other than 4'hF or 4'h0 never matches.
- R7: For every delivery type other than 3'd1, the mask is exactly the set of matched agents, whatever the enable inputs are.
- R8: For delivery type 3'd1 (lowest priority), the search runs as follows:
  - It starts at the agent after the remembered pointer and wraps around.
  - It picks the first matched agent that is enabled, and the mask has exactly that one bit set.
  - The pointer then takes the picked index.
- R9: For lowest-priority delivery with no enabled matched agent, the mask selects the lowest-numbered matched agent, or agent 0 if none matched, and the pointer is left unchanged.
- R10: While `rst_ni` is low, both outputs are zero. The pointer resets to `N_AGENTS-1`, so the first lowest-priority search starts at agent 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| agent_id_i | input | 8*N_AGENTS | Physical ID of each agent, agent k in bits [8k+7:8k] |
| agent_lid_i | input | 8*N_AGENTS | Logical ID of each agent |
| agent_model_i | input | 4*N_AGENTS | Addressing-model code per agent (F flat, 0 cluster) |
| agent_en_i | input | N_AGENTS | Agent enabled for lowest-priority selection |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_src_i | input | IDX_W | Index of the sending agent |
| cmd_dest_i | input | 8 | Destination field |
| cmd_logical_i | input | 1 | 1 = logical addressing, 0 = physical |
| cmd_short_i | input | 2 | Destination shorthand |
| cmd_dlv_i | input | 3 | Delivery type, 3'd1 = lowest priority |
| tgt_valid_o | output | 1 | Result valid pulse |
| tgt_mask_o | output | N_AGENTS | Target mask |

## Verification
The hardest state to reach is a lowest-priority search whose rotating pointer sits in the middle of a sparse candidate set. The search then has to skip disabled candidates and wrap past the top agent. The stimulus reaches this state by issuing a series of lowest-priority commands against the same logical destination, which walks the pointer step by step. It then drops the enables of selected candidates so that the skipping and wrap paths are exercised. A final command with every candidate disabled checks the fallback choice and that the pointer holds, which the next enabled search exposes at the ports.

// File: rtl/ipi_route_pkg.sv
package ipi_route_pkg;
  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [2:0] DLV_LOWPRI    = 3'd1;
  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
  localparam logic [7:0] DEST_BCAST    = 8'hFF;
endpackage

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
  import ipi_route_pkg::*;
#(
  parameter int IDX  = 0,
  parameter int IW   = 3,
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] lid_i,
  input  logic [3:0]      model_i,
  input  logic [IW-1:0]   src_i,
  input  logic [ID_W-1:0] dest_i,
  input  logic            logical_i,
  input  logic [1:0]      short_i,
  output logic            hit_o
);
  localparam int HALF = ID_W / 2;

  logic is_self;
  logic phys_hit;
  logic flat_hit;
  logic clus_hit;
  logic log_hit;

  assign is_self  = (src_i == IW'(IDX));
  assign phys_hit = (dest_i == id_i) || (dest_i == DEST_BCAST);
  assign flat_hit = |(lid_i & dest_i);
  assign clus_hit = (lid_i[ID_W-1:HALF] == dest_i[ID_W-1:HALF]) &&
                    (|(lid_i[HALF-1:0] & dest_i[HALF-1:0]));

  always_comb begin
    unique case (model_i)
      MODEL_FLAT:    log_hit = flat_hit;
      MODEL_CLUSTER: log_hit = clus_hit;
      default:       log_hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (shorthand_e'(short_i))
      SH_DEST:   hit_o = logical_i ? log_hit : phys_hit;
      SH_SELF:   hit_o = is_self;
      SH_ALL:    hit_o = 1'b1;
      SH_OTHERS: hit_o = !is_self;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic [N-1:0] cand_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] pick_o
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] rr_idx;
  logic [IW-1:0] fb_idx;
  logic          rr_found;
  logic [N-1:0]  elig;

  assign elig = cand_i & en_i;

  // rotating search starting one past the last winner
  always_comb begin
    rr_found = 1'b0;
    rr_idx   = ptr_q;
    for (int k = 0; k < N; k++) begin
      if (!rr_found && elig[(32'(ptr_q) + 32'(k) + 32'd1) % 32'(N)]) begin
        rr_found = 1'b1;
        rr_idx   = IW'((32'(ptr_q) + 32'(k) + 32'd1) % 32'(N));
      end
    end
  end

  // fallback: lowest candidate, agent 0 when empty
  always_comb begin
    fb_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (cand_i[k]) fb_idx = IW'(k);
    end
  end

  assign pick_o = N'(1) << (rr_found ? rr_idx : fb_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ptr_q <= IW'(N - 1);
    else if (strobe_i && rr_found)  ptr_q <= rr_idx;
  end

  assert_hold_ptr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && (elig == '0)) |=> $stable(ptr_q));

  assert_pick_enabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && (elig != '0)) |-> ((pick_o & elig) != '0));

  assert_ptr_moves_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && (elig != '0)) |=> (ptr_q != $past(ptr_q)) || ($countones($past(elig)) == 1));
endmodule

// File: rtl/ipi_route.sv
module ipi_route
  import ipi_route_pkg::*;
#(
  parameter int N_AGENTS = 8,
  parameter int ID_W     = 8,
  parameter int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ID_W*N_AGENTS-1:0] agent_id_i,
  input  logic [ID_W*N_AGENTS-1:0] agent_lid_i,
  input  logic [4*N_AGENTS-1:0]    agent_model_i,
  input  logic [N_AGENTS-1:0]      agent_en_i,
  input  logic                     cmd_valid_i,
  input  logic [IDX_W-1:0]         cmd_src_i,
  input  logic [ID_W-1:0]          cmd_dest_i,
  input  logic                     cmd_logical_i,
  input  logic [1:0]               cmd_short_i,
  input  logic [2:0]               cmd_dlv_i,
  output logic                     tgt_valid_o,
  output logic [N_AGENTS-1:0]      tgt_mask_o
);
  logic [N_AGENTS-1:0] cand;
  logic [N_AGENTS-1:0] pick;
  logic [N_AGENTS-1:0] mask_d;
  logic                lowpri;

  assign lowpri = (cmd_dlv_i == DLV_LOWPRI);

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_match
    ipi_dest_match #(.IDX(g), .IW(IDX_W), .ID_W(ID_W)) u_match (
      .id_i      (agent_id_i[g*ID_W +: ID_W]),
      .lid_i     (agent_lid_i[g*ID_W +: ID_W]),
      .model_i   (agent_model_i[g*4 +: 4]),
      .src_i     (cmd_src_i),
      .dest_i    (cmd_dest_i),
      .logical_i (cmd_logical_i),
      .short_i   (cmd_short_i),
      .hit_o     (cand[g])
    );
  end

  ipi_rr_pick #(.N(N_AGENTS), .IW(IDX_W)) u_pick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (cmd_valid_i && lowpri),
    .cand_i   (cand),
    .en_i     (agent_en_i),
    .pick_o   (pick)
  );

  assign mask_d = lowpri ? pick : cand;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_valid_o <= 1'b0;
      tgt_mask_o  <= '0;
    end else begin
      tgt_valid_o <= cmd_valid_i;
      tgt_mask_o  <= cmd_valid_i ? mask_d : '0;
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> tgt_valid_o);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> (!tgt_valid_o && (tgt_mask_o == '0)));

  assert_single_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && lowpri) |=> $onehot(tgt_mask_o));

  assert_others_skip_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !lowpri && (cmd_short_i == SH_OTHERS))
      |=> ((tgt_mask_o & (N_AGENTS'(1) << $past(cmd_src_i))) == '0));

  assert_all_hits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !lowpri && (cmd_short_i == SH_ALL)) |=> (&tgt_mask_o));
endmodule

// File: tb/ipi_route_bench.sv
`timescale 1ns/1ps
module ipi_route_bench;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [8*N-1:0] agent_id, agent_lid;
  logic [4*N-1:0] agent_model;
  logic [N-1:0]   agent_en;
  logic           cmd_valid = 1'b0;
  logic [IW-1:0]  cmd_src = '0;
  logic [7:0]     cmd_dest = '0;
  logic           cmd_logical = 1'b0;
  logic [1:0]     cmd_short = '0;
  logic [2:0]     cmd_dlv = '0;
  logic           tgt_valid;
  logic [N-1:0]   tgt_mask;

  logic [7:0] b_id [N];
  logic [7:0] b_lid[N];
  logic [3:0] b_mod[N];
  logic [N-1:0] b_en;
  int b_ptr = N - 1;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      agent_id[k*8 +: 8]    = b_id[k];
      agent_lid[k*8 +: 8]   = b_lid[k];
      agent_model[k*4 +: 4] = b_mod[k];
    end
    agent_en = b_en;
  end

  ipi_route #(.N_AGENTS(N)) u_ipi_route (
    .clk_i(clk), .rst_ni(rst_n),
    .agent_id_i(agent_id), .agent_lid_i(agent_lid), .agent_model_i(agent_model),
    .agent_en_i(agent_en), .cmd_valid_i(cmd_valid), .cmd_src_i(cmd_src),
    .cmd_dest_i(cmd_dest), .cmd_logical_i(cmd_logical), .cmd_short_i(cmd_short),
    .cmd_dlv_i(cmd_dlv), .tgt_valid_o(tgt_valid), .tgt_mask_o(tgt_mask)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic bit ref_hit(int k, int src, logic [7:0] dest, bit logical, logic [1:0] sh);
    case (sh)
      2'd1: return k == src;
      2'd2: return 1'b1;
      2'd3: return k != src;
      default: begin
        if (!logical) return (dest == b_id[k]) || (dest == 8'hFF);
        if (b_mod[k] == 4'hF) return (b_lid[k] & dest) != 0;
        if (b_mod[k] == 4'h0) return (b_lid[k][7:4] == dest[7:4]) && ((b_lid[k][3:0] & dest[3:0]) != 0);
        return 1'b0;
      end
    endcase
  endfunction

  task automatic send(input int src, input logic [7:0] dest, input bit logical,
                      input logic [1:0] sh, input logic [2:0] dlv, input string tag);
    logic [N-1:0] c;
    logic [N-1:0] e;
    bit found;
    for (int k = 0; k < N; k++) c[k] = ref_hit(k, src, dest, logical, sh);
    if (dlv == 3'd1) begin
      found = 1'b0;
      e = '0;
      for (int s = 1; s <= N; s++) begin
        int idx;
        idx = (b_ptr + s) % N;
        if (!found && c[idx] && b_en[idx]) begin
          found = 1'b1;
          e[idx] = 1'b1;
          b_ptr = idx;
        end
      end
      if (!found) begin
        int lo;
        lo = 0;
        for (int k = N - 1; k >= 0; k--) if (c[k]) lo = k;
        e[lo] = 1'b1;
      end
    end else begin
      e = c;
    end
    @(negedge clk);
    cmd_src = IW'(src); cmd_dest = dest; cmd_logical = logical;
    cmd_short = sh; cmd_dlv = dlv; cmd_valid = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (tgt_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R1 (unexpected valid)", tgt_mask, '0);
        else begin
          logic [N-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(tgt_mask == e, t, tgt_mask, e);
        end
      end else if (tgt_mask != '0) begin
        check(1'b0, "R1 (mask while idle)", tgt_mask, '0);
      end
    end
  end

  task automatic set_flat();
    for (int k = 0; k < N; k++) begin
      b_id[k] = 8'h20 + 8'(k);
      b_lid[k] = 8'(1 << k);
      b_mod[k] = 4'hF;
    end
  endtask

  initial begin
    set_flat();
    b_en = '1;
    repeat (3) @(negedge clk);
    check((tgt_valid == 1'b0) && (tgt_mask == '0), "R10 reset outputs", tgt_mask, '0);
    rst_n = 1'b1;
    @(negedge clk);
    send(0, 8'h22, 0, 2'd0, 3'd0, "R3 physical id");
    send(0, 8'hFF, 0, 2'd0, 3'd0, "R3 physical broadcast");
    send(0, 8'h55, 0, 2'd0, 3'd0, "R3 physical no match");
    send(0, 8'h0A, 1, 2'd0, 3'd0, "R4 flat logical");
    send(5, 8'h22, 0, 2'd1, 3'd0, "R2 self");
    send(3, 8'h00, 1, 2'd2, 3'd0, "R2 all incl");
    send(3, 8'h22, 0, 2'd3, 3'd0, "R2 all excl");
    for (int k = 0; k < N; k++) begin
      b_mod[k] = 4'h0;
      b_lid[k] = {4'(k >> 2), 4'(1 << (k & 3))};
    end
    send(0, 8'h13, 1, 2'd0, 3'd0, "R5 cluster");
    send(0, 8'h0F, 1, 2'd0, 3'd0, "R5 cluster group 0");
    set_flat();
    b_mod[2] = 4'h5;
    send(0, 8'hFF, 1, 2'd0, 3'd0, "R6 bad model");
    b_mod[2] = 4'hF;
    send(0, 8'hFF, 1, 2'd0, 3'd1, "R10 first pick agent 0");
    send(0, 8'hFF, 1, 2'd0, 3'd1, "R8 rotate 1");
    send(0, 8'hFF, 1, 2'd0, 3'd1, "R8 rotate 2");
    send(0, 8'h4A, 1, 2'd0, 3'd1, "R8 sparse pick 3");
    send(0, 8'h4A, 1, 2'd0, 3'd1, "R8 sparse pick 6");
    send(0, 8'h4A, 1, 2'd0, 3'd1, "R8 wrap pick 1");
    b_en[3] = 1'b0;
    send(0, 8'h4A, 1, 2'd0, 3'd1, "R8 skip disabled");
    b_en = '0;
    send(0, 8'h4A, 1, 2'd0, 3'd1, "R9 fallback lowest");
    send(0, 8'h77, 0, 2'd0, 3'd1, "R9 empty to agent 0");
    send(0, 8'hFF, 0, 2'd0, 3'd0, "R7 fixed ignores enable");
    send(2, 8'h00, 0, 2'd3, 3'd4, "R7 other type all excl");
    b_en = '1;
    send(0, 8'hFF, 1, 2'd0, 3'd1, "R9 pointer held");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R1 all results seen", N'(exp_q.size()), '0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule